// File: doc/BRIEF.md
# Data Cache Maintenance Engine

This block is the maintenance sequencer of a direct-mapped, write-back L1 data cache. It carries out two cache-management instructions. Flush copies dirty data back to memory and then invalidates. Discard invalidates without copying anything back, so any modified data in the affected lines is dropped. Each instruction works in one of two scopes. When the register field of the instruction names register zero, it sweeps the whole cache. Otherwise it acts on the single line that holds the byte address supplied as the register value.

The engine holds the valid, dirty and tag bits of the cache. A refill path installs lines through `fill_*`. A lookup path (`probe_*`) reports whether a line address is present and modified. Before acting, the engine checks three things. Privilege below machine mode is an illegal instruction. For the single-line scope only, a missing write permission raises a store fault. A region that is writable but uncacheable turns the request into a no-op. Dirty lines leave through a one-outstanding request/acknowledge writeback port. `busy` stalls the pipeline during multi-cycle work, and each request ends with a one-cycle `done` or `exc_valid` pulse.

Top module: `cmo_engine`

## Requirements
- R1: Flush is recognised when `req_insn` with bits [19:15] cleared equals 32'hFC000073, and discard when it equals 32'hFC200073. Any other word presented with `req_valid` is ignored: no pulse, no busy, and the cache is unchanged.
- R2: If bits [19:15] are zero, the request covers every line. Otherwise it covers only the line selected by `req_rs1`: index bits [OFF_W+IDX_W-1:OFF_W], with a tag compare on the bits above.
- R3: Flush sends each valid dirty targeted line to memory and only then clears its valid and dirty bits. Clean or invalid lines cause no writeback.
- R4: Discard clears valid and dirty on targeted lines and never raises `wb_req`.
- R5: If `req_priv` is not 2'b11 (machine mode), the engine pulses `exc_valid` with `exc_cause` 2 and leaves every line unchanged.
- R6: In single-line scope with `req_wr_ok` low, the engine pulses `exc_valid` with cause 15 if `req_xlate_fault` is high, and cause 7 otherwise. No line changes.
- R7: In single-line scope, if `req_wr_ok` is high and `req_cacheable` is low, the engine pulses `done` with no effect on the cache and no writeback.
- R8: Any byte offset inside a line selects the whole line. `wb_addr` is the line-aligned address, with its low OFF_W bits zero.
- R9: The whole-cache sweep visits indices in ascending order with at most one writeback outstanding. `wb_req` and `wb_addr` hold steady until `wb_ack`, and the line is cleared on the acknowledge cycle.
- R10: A single-line request that misses (tag mismatch or invalid line), or that needs no writeback, pulses `done` in the cycle right after acceptance, with no memory traffic.
- R11: `busy` is high from acceptance of a multi-cycle operation until its end. `done` and `exc_valid` are single-cycle, mutually exclusive, and occur only while `busy` is low. Requests that arrive while `busy` is high are ignored.
- R12: The whole-cache scope ignores `req_wr_ok`, `req_cacheable` and `req_xlate_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all lines |
| req_valid | input | 1 | Instruction presented this cycle |
| req_insn | input | 32 | Instruction word |
| req_rs1 | input | ADDR_W | Register value (byte address) |
| req_priv | input | 2 | Current privilege, 2'b11 = machine |
| req_wr_ok | input | 1 | Write permitted at `req_rs1` |
| req_cacheable | input | 1 | `req_rs1` lies in a cacheable region |
| req_xlate_fault | input | 1 | Missing permission comes from translation |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle successful completion |
| exc_valid | output | 1 | One-cycle exception report |
| exc_cause | output | 4 | Exception cause (2, 7 or 15) |
| wb_req | output | 1 | Line writeback request |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_ack | input | 1 | Memory accepted the writeback |
| fill_en | input | 1 | Install a line |
| fill_line | input | ADDR_W-OFF_W | Line address to install |
| fill_dirty | input | 1 | Installed line is modified |
| probe_line | input | ADDR_W-OFF_W | Line address to look up |
| probe_hit | output | 1 | Probed line is valid and matches |
| probe_dirty | output | 1 | Probed line is dirty |

## Verification
The assertions check on every cycle the protocol rules. A pending writeback holds its request and address until acknowledged. Completion and exception pulses never coincide and never occur while busy. A writeback happens only inside a busy period. Busy starts only from a machine-mode request. Only the bench scenarios can show that the right lines are written back, in ascending order, with the right addresses. They also show that discard loses dirty data, that faults and no-ops leave lines intact, and that unrecognised words and requests during busy are ignored.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
   localparam logic [31:0] ENC_FLUSH     = 32'hFC000073;
   localparam logic [31:0] ENC_DISCARD   = 32'hFC200073;
   localparam logic [31:0] RS1_FIELD_MSK = 32'h000F8000;
   localparam logic [1:0]  PRIV_MACHINE  = 2'b11;
   localparam logic [3:0]  CAUSE_ILLEGAL = 4'd2;
   localparam logic [3:0]  CAUSE_ST_ACC  = 4'd7;
   localparam logic [3:0]  CAUSE_ST_PAGE = 4'd15;

   typedef enum logic [1:0] {OP_NONE, OP_FLUSH, OP_DISCARD} cmo_op_e;
   typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_LINE_WB} cmo_state_e;
endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
   import cmo_pkg::*;
(
   input  logic [31:0] insn,
   output cmo_op_e     op,
   output logic        all_lines
);
   logic [31:0] base;

   always_comb begin
      base = insn & ~RS1_FIELD_MSK;
      if (base == ENC_FLUSH)        op = OP_FLUSH;
      else if (base == ENC_DISCARD) op = OP_DISCARD;
      else                          op = OP_NONE;
      all_lines = (insn[19:15] == 5'd0);
   end
endmodule

// File: rtl/cmo_tag_array.sv
module cmo_tag_array #(
   parameter int SETS  = 8,
   parameter int TAG_W = 25,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output logic             a_valid,
   output logic             a_dirty,
   output logic [TAG_W-1:0] a_tag,
   input  logic [IDX_W-1:0] b_idx,
   output logic             b_valid,
   output logic             b_dirty,
   output logic [TAG_W-1:0] b_tag,
   input  logic             inv_en,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic [TAG_W-1:0] ins_tag,
   input  logic             ins_dirty
);
   logic [SETS-1:0]            valid_all;
   logic [SETS-1:0]            dirty_all;
   logic [SETS-1:0][TAG_W-1:0] tag_all;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic             v_q;
      logic             d_q;
      logic [TAG_W-1:0] t_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
         end else if (inv_en && inv_idx == IDX_W'(s)) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else if (ins_en && ins_idx == IDX_W'(s)) begin
            v_q <= 1'b1;
            d_q <= ins_dirty;
            t_q <= ins_tag;
         end
      end

      assign valid_all[s] = v_q;
      assign dirty_all[s] = d_q;
      assign tag_all[s]   = t_q;
   end

   assign a_valid = valid_all[a_idx];
   assign a_dirty = dirty_all[a_idx];
   assign a_tag   = tag_all[a_idx];
   assign b_valid = valid_all[b_idx];
   assign b_dirty = dirty_all[b_idx];
   assign b_tag   = tag_all[b_idx];
endmodule

// File: rtl/cmo_engine.sv
module cmo_engine
   import cmo_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 8,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(SETS),
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
   localparam int LINE_W    = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       req_insn,
   input  logic [ADDR_W-1:0] req_rs1,
   input  logic [1:0]        req_priv,
   input  logic              req_wr_ok,
   input  logic              req_cacheable,
   input  logic              req_xlate_fault,
   output logic              busy,
   output logic              done,
   output logic              exc_valid,
   output logic [3:0]        exc_cause,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_ack,
   input  logic              fill_en,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              fill_dirty,
   input  logic [LINE_W-1:0] probe_line,
   output logic              probe_hit,
   output logic              probe_dirty
);
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_BYTES < 4 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the chosen geometry");
   end

   cmo_state_e       state_q, state_d;
   logic             flush_q, flush_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             done_d, exc_d;
   logic [3:0]       cause_d;

   cmo_op_e          op;
   logic             all_lines;
   logic [IDX_W-1:0] req_idx;
   logic [TAG_W-1:0] req_tag;
   logic [IDX_W-1:0] rd_idx;
   logic             a_valid, a_dirty, b_valid, b_dirty;
   logic [TAG_W-1:0] a_tag, b_tag;
   logic             inv_en;
   logic             accept;
   logic             last_idx;

   cmo_decode u_dec (
      .insn      (req_insn),
      .op        (op),
      .all_lines (all_lines)
   );

   assign req_idx  = req_rs1[OFF_W +: IDX_W];
   assign req_tag  = req_rs1[ADDR_W-1 -: TAG_W];
   assign rd_idx   = (state_q == ST_IDLE) ? req_idx : idx_q;
   assign accept   = req_valid && (state_q == ST_IDLE) && (op != OP_NONE);
   assign last_idx = (idx_q == IDX_W'(SETS - 1));

   cmo_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_idx     (rd_idx),
      .a_valid   (a_valid),
      .a_dirty   (a_dirty),
      .a_tag     (a_tag),
      .b_idx     (probe_line[IDX_W-1:0]),
      .b_valid   (b_valid),
      .b_dirty   (b_dirty),
      .b_tag     (b_tag),
      .inv_en    (inv_en),
      .inv_idx   (rd_idx),
      .ins_en    (fill_en),
      .ins_idx   (fill_line[IDX_W-1:0]),
      .ins_tag   (fill_line[LINE_W-1 -: TAG_W]),
      .ins_dirty (fill_dirty)
   );

   assign probe_hit   = b_valid && (b_tag == probe_line[LINE_W-1 -: TAG_W]);
   assign probe_dirty = probe_hit && b_dirty;

   always_comb begin
      state_d = state_q;
      flush_d = flush_q;
      idx_d   = idx_q;
      done_d  = 1'b0;
      exc_d   = 1'b0;
      cause_d = exc_cause;
      inv_en  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               flush_d = (op == OP_FLUSH);
               if (req_priv != PRIV_MACHINE) begin
                  exc_d   = 1'b1;
                  cause_d = CAUSE_ILLEGAL;
               end else if (all_lines) begin
                  state_d = ST_WALK;
                  idx_d   = '0;
               end else if (!req_wr_ok) begin
                  exc_d   = 1'b1;
                  cause_d = req_xlate_fault ? CAUSE_ST_PAGE : CAUSE_ST_ACC;
               end else if (!req_cacheable || !a_valid || a_tag != req_tag) begin
                  done_d = 1'b1;
               end else if (op == OP_FLUSH && a_dirty) begin
                  state_d = ST_LINE_WB;
                  idx_d   = req_idx;
               end else begin
                  inv_en = 1'b1;
                  done_d = 1'b1;
               end
            end
         end
         ST_WALK: begin
            if (!(flush_q && a_valid && a_dirty) || wb_ack) begin
               inv_en = 1'b1;
               if (last_idx) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end else begin
                  idx_d = idx_q + 1'b1;
               end
            end
         end
         ST_LINE_WB: begin
            if (wb_ack) begin
               inv_en  = 1'b1;
               done_d  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         flush_q   <= 1'b0;
         idx_q     <= '0;
         done      <= 1'b0;
         exc_valid <= 1'b0;
         exc_cause <= 4'd0;
      end else begin
         state_q   <= state_d;
         flush_q   <= flush_d;
         idx_q     <= idx_d;
         done      <= done_d;
         exc_valid <= exc_d;
         exc_cause <= cause_d;
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign wb_req  = (state_q == ST_LINE_WB) ||
                    (state_q == ST_WALK && flush_q && a_valid && a_dirty);
   assign wb_addr = {a_tag, idx_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/cmo_engine_chk.sv
module cmo_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        req_priv,
   input logic              busy,
   input logic              done,
   input logic              exc_valid,
   input logic [3:0]        exc_cause,
   input logic              wb_req,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              wb_ack
);
   p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)))
      else $error("writeback request dropped or address moved before ack");

   p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && exc_valid))
      else $error("done and exception pulsed together");

   p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || exc_valid) |-> !busy)
      else $error("completion reported while busy");

   p_wb_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> busy)
      else $error("writeback outside an operation");

   p_busy_mmode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(req_priv) == 2'b11))
      else $error("operation started below machine mode");

   p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_cause == 4'd2 || exc_cause == 4'd7 || exc_cause == 4'd15))
      else $error("unexpected exception cause");
endmodule

bind cmo_engine cmo_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_priv  (req_priv),
   .busy      (busy),
   .done      (done),
   .exc_valid (exc_valid),
   .exc_cause (exc_cause),
   .wb_req    (wb_req),
   .wb_addr   (wb_addr),
   .wb_ack    (wb_ack)
);

// File: tb/cmo_engine_test.sv
module cmo_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int ACK_DLY    = 3;
   localparam logic [31:0] FL_ALL = 32'hFC000073;
   localparam logic [31:0] DC_ALL = 32'hFC200073;
   localparam logic [31:0] FL_R13 = 32'hFC068073;
   localparam logic [31:0] DC_R13 = 32'hFC268073;

   typedef struct packed {
      logic [31:0] insn;
      logic [31:0] rs1;
      logic [1:0]  priv;
      logic        wr;
      logic        cach;
      logic        pgf;
      logic        exp_exc;
      logic [3:0]  cause;
      logic [3:0]  wbn;
      logic [31:0] wb0;
      logic [31:0] probe;
      logic        hit;
      logic        dirty;
      logic [3:0]  lat;
   } vec_t;

   // lines 0x80001000 + 16*i, i = 0..7, dirty when i is odd
   localparam vec_t VEC [14] = '{
      '{FL_ALL, 32'h0,        2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd4, 32'h80001010, 32'h80001030, 1'b0, 1'b0, 4'd0},
      '{DC_ALL, 32'h0,        2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0, 32'h0,        32'h80001030, 1'b0, 1'b0, 4'd0},
      '{FL_R13, 32'h80001034, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd1, 32'h80001030, 32'h80001030, 1'b0, 1'b0, 4'd0},
      '{FL_R13, 32'h80001024, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0, 32'h0,        32'h80001020, 1'b0, 1'b0, 4'd1},
      '{DC_R13, 32'h80001038, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0, 32'h0,        32'h80001030, 1'b0, 1'b0, 4'd1},
      '{FL_R13, 32'h80001034, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2,  4'd0, 32'h0,        32'h80001030, 1'b1, 1'b1, 4'd1},
      '{DC_ALL, 32'h0,        2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2,  4'd0, 32'h0,        32'h80001070, 1'b1, 1'b1, 4'd1},
      '{FL_R13, 32'h80001034, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7,  4'd0, 32'h0,        32'h80001030, 1'b1, 1'b1, 4'd1},
      '{DC_R13, 32'h80001038, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 4'd15, 4'd0, 32'h0,        32'h80001030, 1'b1, 1'b1, 4'd1},
      '{FL_R13, 32'h80001034, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd0, 32'h0,        32'h80001030, 1'b1, 1'b1, 4'd1},
      '{FL_R13, 32'h90001034, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0, 32'h0,        32'h80001030, 1'b1, 1'b1, 4'd1},
      '{FL_ALL, 32'h0,        2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  4'd4, 32'h80001010, 32'h80001070, 1'b0, 1'b0, 4'd0},
      '{DC_R13, 32'h8000105C, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0, 32'h0,        32'h80001050, 1'b0, 1'b0, 4'd1},
      '{FL_R13, 32'h8000107F, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd1, 32'h80001070, 32'h80001070, 1'b0, 1'b0, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_insn = '0;
   logic [31:0] req_rs1 = '0;
   logic [1:0]  req_priv = 2'd3;
   logic        req_wr_ok = 1'b1;
   logic        req_cacheable = 1'b1;
   logic        req_xlate_fault = 1'b0;
   logic        busy, done, exc_valid, wb_req, probe_hit, probe_dirty;
   logic [3:0]  exc_cause;
   logic [31:0] wb_addr;
   logic        wb_ack = 1'b0;
   logic        fill_en = 1'b0;
   logic [27:0] fill_line = '0;
   logic        fill_dirty = 1'b0;
   logic [27:0] probe_line = '0;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int wb_n = 0;
   int dly = 0;
   logic [31:0] wb_log [8];

   always #(CLK_PERIOD / 2) clk = ~clk;

   cmo_engine uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insn(req_insn),
      .req_rs1(req_rs1), .req_priv(req_priv), .req_wr_ok(req_wr_ok),
      .req_cacheable(req_cacheable), .req_xlate_fault(req_xlate_fault),
      .busy(busy), .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
      .fill_en(fill_en), .fill_line(fill_line), .fill_dirty(fill_dirty),
      .probe_line(probe_line), .probe_hit(probe_hit), .probe_dirty(probe_dirty)
   );

   // memory side: acknowledge each writeback after ACK_DLY cycles, log it
   always @(negedge clk) begin
      if (wb_ack) wb_ack <= 1'b0;
      else if (wb_req) begin
         if (dly == ACK_DLY) begin
            wb_ack <= 1'b1;
            if (wb_n < 8) wb_log[wb_n] = wb_addr;
            wb_n = wb_n + 1;
            dly = 0;
         end else dly = dly + 1;
      end
   end

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      wb_n = 0;
   endtask

   task automatic fill_all();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         fill_en = 1'b1;
         fill_line = 28'h8000100 + 28'(i);
         fill_dirty = i[0];
      end
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic probe(input logic [31:0] a, output logic h, output logic d);
      probe_line = a[31:4];
      #1;
      h = probe_hit;
      d = probe_dirty;
   endtask

   // drives one request; returns negedges until done/exc and which one
   task automatic issue(input logic [31:0] insn, input logic [31:0] rs1, input logic [1:0] priv,
                        input logic wr, input logic cach, input logic pgf,
                        output int lat, output logic got_exc, output logic [3:0] cause);
      @(negedge clk);
      req_valid = 1'b1; req_insn = insn; req_rs1 = rs1; req_priv = priv;
      req_wr_ok = wr; req_cacheable = cach; req_xlate_fault = pgf;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!(done || exc_valid) && lat < 500) begin
         @(negedge clk);
         lat = lat + 1;
      end
      got_exc = exc_valid;
      cause = exc_cause;
   endtask

   initial begin
      int lat;
      logic ge, h, d;
      logic [3:0] c;

      // reset state (R11)
      do_reset();
      probe(32'h80001000, h, d);
      chk(!busy && !done && !exc_valid && !wb_req, "R11 reset outputs idle",
          {busy, done, exc_valid, wb_req}, 0);
      chk(!h, "R2 reset cache empty", h, 0);

      // table of vectors
      for (int v = 0; v < 14; v++) begin
         do_reset();
         fill_all();
         wb_n = 0;
         issue(VEC[v].insn, VEC[v].rs1, VEC[v].priv, VEC[v].wr, VEC[v].cach, VEC[v].pgf, lat, ge, c);
         chk(ge == VEC[v].exp_exc && (!ge || c == VEC[v].cause),
             $sformatf("R5/R6/R7 v%0d outcome exc/cause", v), {ge, c}, {VEC[v].exp_exc, VEC[v].cause});
         chk(wb_n == int'(VEC[v].wbn), $sformatf("R3/R4/R12 v%0d writeback count", v), wb_n, VEC[v].wbn);
         if (VEC[v].wbn != 0)
            chk(wb_log[0] == VEC[v].wb0, $sformatf("R8 v%0d first writeback address", v), wb_log[0], VEC[v].wb0);
         probe(VEC[v].probe, h, d);
         chk(h == VEC[v].hit && d == VEC[v].dirty, $sformatf("R2/R4 v%0d line state after", v),
             {h, d}, {VEC[v].hit, VEC[v].dirty});
         if (VEC[v].lat != 0)
            chk(lat == int'(VEC[v].lat), $sformatf("R10 v%0d completion latency", v), lat, VEC[v].lat);
      end

      // R9: sweep order, busy held during sweep
      do_reset();
      fill_all();
      wb_n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_insn = FL_ALL; req_priv = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy, "R11 busy after sweep accepted", busy, 1);
      while (!done && cycles < 90000) @(negedge clk);
      for (int k = 0; k < 4; k++)
         chk(wb_log[k] == 32'h80001010 + 32'(k * 32), "R9 ascending writeback order",
             wb_log[k], 32'h80001010 + 32'(k * 32));

      // R1: unrecognised word ignored
      do_reset();
      fill_all();
      @(negedge clk);
      req_valid = 1'b1; req_insn = 32'hFC400073; req_rs1 = 32'h80001030;
      @(negedge clk);
      req_valid = 1'b0;
      ge = 1'b0;
      for (int k = 0; k < 4; k++) begin
         if (done || exc_valid || busy) ge = 1'b1;
         @(negedge clk);
      end
      chk(!ge, "R1 foreign word produced no activity", ge, 0);
      probe(32'h80001030, h, d);
      chk(h && d, "R1 foreign word left line intact", {h, d}, 2'b11);

      // R11: request during busy ignored
      do_reset();
      fill_all();
      @(negedge clk);
      req_valid = 1'b1; req_insn = FL_R13; req_rs1 = 32'h80001030;
      req_wr_ok = 1'b1; req_cacheable = 1'b1; req_priv = 2'd3;
      @(negedge clk);
      req_insn = DC_ALL;
      chk(busy, "R11 busy during single writeback", busy, 1);
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && cycles < 90000) @(negedge clk);
      @(negedge clk);
      chk(!busy && !done, "R11 no second operation started", {busy, done}, 0);
      probe(32'h80001010, h, d);
      chk(h && d, "R11 discard during busy was ignored", {h, d}, 2'b11);
      probe(32'h80001030, h, d);
      chk(!h, "R3 flushed line invalid", h, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule